// File: doc/BRIEF.md
# Coprocessor Memory-Transfer Responder

This block is the coprocessor side of the memory load and store instructions. It watches every instruction word that the processor issues. It claims an instruction only when the word belongs to the coprocessor transfer class and its coprocessor-number field equals the number this instance was built with. Once it has claimed an instruction, the processor supplies the addresses and raises one transfer strobe per word. The responder then supplies store data from, or takes load data into, an internal file of sixteen 32-bit registers.

The responder, not the processor, decides how long the burst is. A short transfer moves the one register named in the instruction. A long transfer moves that register and every register above it. The responder flags the final word in the same cycle as its strobe.

Loaded words are held aside and reach the register file only when the whole burst ends without an abort. An aborted instruction therefore leaves no trace, and reissuing it gives the same result.

Top module: `cpx_resp`

## Requirements
- R1: `accept_o` is high in a cycle only when all of the following hold in that cycle: `issue_i` is high, instruction bits 27:25 equal 3'b110, bits 11:8 equal the parameter `CP_ID`, and the responder is idle. When it is high, the responder becomes busy at the next clock edge.
- R2: The first register moved is the one numbered by instruction bits 15:12. Each later word uses the next higher register number, one word per `xfer_i` strobe.
- R3: Instruction bit 22 picks the burst length. When it is 0, exactly one word is moved. When it is 1, the words for registers from the first register up to register 15 are moved, which is 16 minus the first register number.
- R4: `last_o` is high in the same cycle as the strobe of the final word, and in no other cycle. The responder is idle at the next clock edge.
- R5: When bit 20 is 0 (store), `st_data_o` shows the register at the current position while busy, and 0 at all other times. A store leaves the register file unchanged.
- R6: When bit 20 is 1 (load), the `ld_data_i` word taken with each strobe is meant for the register at the current position. All of these words are written to the register file together, and only when the burst completes.
- R7: If `abort_i` is high while busy, the responder returns to idle at the next edge and discards every word loaded by that instruction. Reissuing the instruction then gives the same result as a single run with no abort.
- R8: If `abort_i` is high in the cycle of the final strobe, the abort takes priority: `last_o` stays low and nothing is written to the register file.
- R9: An issue while busy is not accepted and does not disturb the burst in progress. `xfer_i` and `abort_i` while idle have no effect.
- R10: After reset the responder is idle, `accept_o`, `last_o` and `st_data_o` are 0, and all registers read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| insn_i | input | 32 | Issued instruction word |
| issue_i | input | 1 | Instruction issue strobe |
| xfer_i | input | 1 | One-word transfer strobe |
| ld_data_i | input | 32 | Load data from memory |
| abort_i | input | 1 | Memory abort for the current word |
| accept_o | output | 1 | Instruction claimed (combinational, same cycle as issue) |
| st_data_o | output | 32 | Store data for the current word |
| last_o | output | 1 | Current strobe carries the final word |

## Verification
Two events can fall in the same cycle: a memory abort and the final transfer strobe. The bench provokes this in directed cases and in random cases by raising `abort_i` on the last word of both short and long loads. It judges the result by checking that `last_o` stays low in that cycle. It then reads the whole register file back with a long store and compares every register with a model in which the aborted load was never applied. A new issue arriving during a burst is also provoked in random idle gaps; it must not be accepted and must leave the burst sequence intact.

// File: rtl/cpx_pkg.sv
package cpx_pkg;
  localparam int INSN_W   = 32;
  localparam int CLS_LSB  = 25;
  localparam int N_BIT    = 22;
  localparam int L_BIT    = 20;
  localparam int CRD_LSB  = 12;
  localparam int CP_LSB   = 8;
  localparam int CRD_W    = 4;
  localparam int CP_W     = 4;
  localparam logic [2:0] CLS_CODE = 3'b110;

  typedef struct packed {
    logic             hit;
    logic             long_x;
    logic             load;
    logic [CRD_W-1:0] crd;
  } dec_t;
endpackage

// File: rtl/cpx_decode.sv
module cpx_decode
  import cpx_pkg::*;
#(
  parameter logic [CP_W-1:0] CP_ID = 4'd5
) (
  input  logic [INSN_W-1:0] insn_i,
  output dec_t              dec_o
);
  always_comb begin
    dec_o.hit    = (insn_i[CLS_LSB+2:CLS_LSB] == CLS_CODE) &&
                   (insn_i[CP_LSB+CP_W-1:CP_LSB] == CP_ID);
    dec_o.long_x = insn_i[N_BIT];
    dec_o.load   = insn_i[L_BIT];
    dec_o.crd    = insn_i[CRD_LSB+CRD_W-1:CRD_LSB];
  end
endmodule

// File: rtl/cpx_seq.sv
module cpx_seq
  import cpx_pkg::*;
#(
  parameter int IDX_W = CRD_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             issue_i,
  input  dec_t             dec_i,
  input  logic             xfer_i,
  input  logic             abort_i,
  output logic             start_o,
  output logic             busy_o,
  output logic             load_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             step_o,
  output logic             fin_o,
  output logic             kill_o
);
  localparam logic [IDX_W-1:0] TOP_IDX = '1;

  logic             busy_q, load_q;
  logic [IDX_W-1:0] idx_q, end_q;

  assign start_o = issue_i & dec_i.hit & ~busy_q;
  assign step_o  = busy_q & xfer_i & ~abort_i;
  assign fin_o   = step_o & (idx_q == end_q);
  assign kill_o  = busy_q & abort_i;
  assign busy_o  = busy_q;
  assign load_o  = load_q;
  assign idx_o   = idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      load_q <= 1'b0;
      idx_q  <= '0;
      end_q  <= '0;
    end else if (start_o) begin
      busy_q <= 1'b1;
      load_q <= dec_i.load;
      idx_q  <= dec_i.crd;
      end_q  <= dec_i.long_x ? TOP_IDX : dec_i.crd;
    end else if (kill_o || fin_o) begin
      busy_q <= 1'b0;
    end else if (step_o) begin
      idx_q <= idx_q + 1'b1;
    end
  end
endmodule

// File: rtl/cpx_regs.sv
module cpx_regs #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              commit_i,
  input  logic              drop_i
);
  localparam int NREG = 1 << IDX_W;

  logic [DATA_W-1:0] rf_q [NREG];
  logic [DATA_W-1:0] sh_q [NREG];
  logic [NREG-1:0]   shv_q;

  assign rd_data_o = rf_q[rd_idx_i];

  for (genvar g = 0; g < NREG; g++) begin : g_ent
    logic hit_w;
    assign hit_w = wr_en_i && (wr_idx_i == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rf_q[g]  <= '0;
        sh_q[g]  <= '0;
        shv_q[g] <= 1'b0;
      end else if (commit_i) begin
        if (hit_w)         rf_q[g] <= wr_data_i;
        else if (shv_q[g]) rf_q[g] <= sh_q[g];
        shv_q[g] <= 1'b0;
      end else if (drop_i) begin
        shv_q[g] <= 1'b0;
      end else if (hit_w) begin
        sh_q[g]  <= wr_data_i;
        shv_q[g] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/cpx_resp.sv
module cpx_resp
  import cpx_pkg::*;
#(
  parameter logic [CP_W-1:0] CP_ID  = 4'd5,
  parameter int              DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [INSN_W-1:0] insn_i,
  input  logic              issue_i,
  input  logic              xfer_i,
  input  logic [DATA_W-1:0] ld_data_i,
  input  logic              abort_i,
  output logic              accept_o,
  output logic [DATA_W-1:0] st_data_o,
  output logic              last_o
);
  localparam int IDX_W = CRD_W;

  dec_t             dec;
  logic             start, busy, load, step, fin, kill;
  logic [IDX_W-1:0] idx;
  logic [DATA_W-1:0] rd_data;

  cpx_decode #(.CP_ID(CP_ID)) u_dec (
    .insn_i (insn_i),
    .dec_o  (dec)
  );

  cpx_seq #(.IDX_W(IDX_W)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .issue_i (issue_i),
    .dec_i   (dec),
    .xfer_i  (xfer_i),
    .abort_i (abort_i),
    .start_o (start),
    .busy_o  (busy),
    .load_o  (load),
    .idx_o   (idx),
    .step_o  (step),
    .fin_o   (fin),
    .kill_o  (kill)
  );

  cpx_regs #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_idx_i  (idx),
    .rd_data_o (rd_data),
    .wr_en_i   (step & load),
    .wr_idx_i  (idx),
    .wr_data_i (ld_data_i),
    .commit_i  (fin & load),
    .drop_i    (kill | start)
  );

  assign accept_o  = start;
  assign last_o    = fin;
  assign st_data_o = (busy && !load) ? rd_data : '0;
endmodule

// File: rtl/cpx_resp_chk.sv
module cpx_resp_chk
  import cpx_pkg::*;
#(
  parameter logic [CP_W-1:0] CP_ID = 4'd5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [INSN_W-1:0] insn_i,
  input logic              issue_i,
  input logic              xfer_i,
  input logic              abort_i,
  input logic              accept_o,
  input logic              last_o
);
  logic           ck_busy;
  logic [CRD_W:0] ck_left;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ck_busy <= 1'b0;
      ck_left <= '0;
    end else if (accept_o) begin
      ck_busy <= 1'b1;
      ck_left <= insn_i[N_BIT]
               ? (CRD_W+1)'(16) - {1'b0, insn_i[CRD_LSB+CRD_W-1:CRD_LSB]}
               : (CRD_W+1)'(1);
    end else if (ck_busy && abort_i) begin
      ck_busy <= 1'b0;
    end else if (ck_busy && xfer_i) begin
      ck_left <= ck_left - 1'b1;
      if (ck_left == 1) ck_busy <= 1'b0;
    end
  end

  AST_ACCEPT_ON_ISSUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |-> issue_i);  // R1
  AST_ACCEPT_OWN_CP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |-> (insn_i[CP_LSB+CP_W-1:CP_LSB] == CP_ID && insn_i[CLS_LSB+2:CLS_LSB] == CLS_CODE));  // R1
  AST_LAST_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ck_busy && xfer_i && !abort_i) |-> (last_o == (ck_left == 1)));  // R3
  AST_LAST_WITH_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> xfer_i);  // R4
  AST_ABORT_NO_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |-> !last_o);  // R8
  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ck_busy |-> !accept_o);  // R9
  AST_IDLE_NO_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ck_busy |-> !last_o);  // R9
endmodule

bind cpx_resp cpx_resp_chk #(.CP_ID(CP_ID)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .insn_i   (insn_i),
  .issue_i  (issue_i),
  .xfer_i   (xfer_i),
  .abort_i  (abort_i),
  .accept_o (accept_o),
  .last_o   (last_o)
);

// File: tb/tb_cpx_resp.sv
module tb_cpx_resp;
  localparam logic [3:0] MY_CP = 4'd5;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] insn_i = '0;
  logic        issue_i = 1'b0, xfer_i = 1'b0, abort_i = 1'b0;
  logic [31:0] ld_data_i = '0;
  logic        accept_o, last_o;
  logic [31:0] st_data_o;

  int checks = 0, errors = 0;
  logic [31:0] model [16];

  always #10 clk_i = ~clk_i;

  cpx_resp #(.CP_ID(MY_CP)) dut (.*);

  function automatic logic [31:0] mk_insn(logic [3:0] cp, logic [3:0] crd, logic n, logic l);
    return {4'hE, 3'b110, 1'b1, 1'b1, n, 1'b0, l, 4'h3, crd, cp, 8'h04};
  endfunction

  function automatic int xfer_len(logic [3:0] crd, logic n);
    return n ? 16 - int'(crd) : 1;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
    end
  endtask

  // one full instruction; abort_at < 0 means no abort
  task automatic run(logic [3:0] crd, logic n, logic l, int abort_at, bit gaps);
    int len = xfer_len(crd, n);
    logic [31:0] stash [16];
    @(negedge clk_i);
    insn_i = mk_insn(MY_CP, crd, n, l); issue_i = 1'b1;
    #2 chk("R1 accept", {31'b0, accept_o}, 32'd1);
    @(negedge clk_i); issue_i = 1'b0;
    for (int k = 0; k < len; k++) begin
      if (gaps && ($urandom % 3 == 0)) begin
        insn_i = mk_insn(MY_CP, 4'd0, 1'b1, ~l); issue_i = 1'b1;
        #2 chk("R9 accept while busy", {31'b0, accept_o}, 32'd0);
        chk("R9 no last in gap", {31'b0, last_o}, 32'd0);
        @(negedge clk_i); issue_i = 1'b0;
      end
      xfer_i = 1'b1; ld_data_i = $urandom; abort_i = (k == abort_at);
      #2;
      chk(abort_i ? "R8 last under abort" : "R4 last flag", {31'b0, last_o},
          {31'b0, (k == len-1) && !abort_i});
      if (!l) chk("R5/R2 store data", st_data_o, model[crd+k]);
      stash[crd+k] = ld_data_i;
      @(negedge clk_i);
      xfer_i = 1'b0; abort_i = 1'b0;
      if (k == abort_at) break;
    end
    if (l && abort_at < 0)
      for (int k = 0; k < len; k++) model[crd+k] = stash[crd+k];
  endtask

  // read whole file with long store starting at 0 and compare
  task automatic dump(string req);
    @(negedge clk_i);
    insn_i = mk_insn(MY_CP, 4'd0, 1'b1, 1'b0); issue_i = 1'b1;
    @(negedge clk_i); issue_i = 1'b0;
    for (int k = 0; k < 16; k++) begin
      xfer_i = 1'b1;
      #2 chk(req, st_data_o, model[k]);
      @(negedge clk_i); xfer_i = 1'b0;
    end
  endtask

  initial begin
    #4000000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h0C0FFEE5));
    for (int i = 0; i < 16; i++) model[i] = '0;
    #1;
    chk("R10 accept reset", {31'b0, accept_o}, 32'd0);
    chk("R10 last reset", {31'b0, last_o}, 32'd0);
    chk("R10 st_data reset", st_data_o, 32'd0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    dump("R10 regs zero");

    // foreign coprocessor and wrong class, then stray strobes while idle
    @(negedge clk_i);
    insn_i = mk_insn(4'd2, 4'd0, 1'b1, 1'b1); issue_i = 1'b1;
    #2 chk("R1 foreign cp", {31'b0, accept_o}, 32'd0);
    @(negedge clk_i);
    insn_i = mk_insn(MY_CP, 4'd0, 1'b1, 1'b1) ^ 32'h0400_0000;
    #2 chk("R1 wrong class", {31'b0, accept_o}, 32'd0);
    @(negedge clk_i); issue_i = 1'b0;
    for (int k = 0; k < 4; k++) begin
      xfer_i = 1'b1; abort_i = k[0]; ld_data_i = 32'hDEAD0000 + k;
      #2 chk("R9 idle strobe", {31'b0, last_o}, 32'd0);
      @(negedge clk_i);
    end
    xfer_i = 1'b0; abort_i = 1'b0;
    dump("R9 idle strobes no effect");

    // directed: long load from 0, short load at 15, short store at 7
    run(4'd0, 1'b1, 1'b1, -1, 1'b0);
    dump("R6 long load");
    run(4'd15, 1'b0, 1'b1, -1, 1'b0);
    run(4'd15, 1'b1, 1'b1, -1, 1'b0);
    run(4'd7, 1'b0, 1'b0, -1, 1'b0);
    dump("R3 short/edge loads");
    // abort mid-burst, then reissue
    run(4'd4, 1'b1, 1'b1, 5, 1'b0);
    dump("R7 abort discards");
    run(4'd4, 1'b1, 1'b1, -1, 1'b0);
    dump("R7 reissue");
    // abort on final word, long and short
    run(4'd10, 1'b1, 1'b1, 5, 1'b0);
    run(4'd3, 1'b0, 1'b1, 0, 1'b0);
    dump("R8 abort on last");
    // stores leave file unchanged
    run(4'd2, 1'b1, 1'b0, -1, 1'b1);
    dump("R5 store no change");

    for (int t = 0; t < 60; t++) begin
      logic [3:0] crd = 4'($urandom);
      logic n = 1'($urandom);
      logic l = 1'($urandom);
      int len = xfer_len(crd, n);
      int ab = ($urandom % 4 == 0) ? int'($urandom % len) : -1;
      run(crd, n, l, ab, 1'b1);
    end
    dump("R2 random final file");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule